// File: doc/BRIEF.md
# SCSI Bus Arbitration Controller

This block runs the arbitration phase of a SCSI initiator or target. Software writes a one-hot device ID into the outgoing data value and raises an arbitrate control bit. The block watches the sampled BSY and SEL lines for a bus-free window and then drives BSY together with its own ID bit. After a fixed arbitration delay it compares its ID against the other IDs on the data lines and settles the result.

Software learns the outcome only by polling a status byte. It carries an arbitration-in-progress flag at bit 6 and a lost-arbitration flag at bit 5. No interrupt is raised. After a win the block keeps BSY and its ID on the bus until software clears the arbitrate bit or hands over to selection by raising its select request. Selection itself, data transfer and DMA sit outside this block.

Top module: `scsi_arb_ctrl`

## Requirements
- R1: After reset, drv_bsy is 0, drv_data is 0 and status is 0.
- R2: Arbitration starts only when arb_en is 1 and own_id has exactly one bit set. When it runs, drv_data equals own_id. With any other own_id the block drives nothing.
- R3: The block drives BSY only after bus_bsy_in and bus_sel_in have both been 0 for FREE_CYC consecutive clock edges. A busy cycle, including SEL alone, restarts the count. With the bus busy beforehand, drv_bsy is first seen high FREE_CYC+1 cycles after both lines go low.
- R4: While BSY is being driven, status reads 8'h40 (bit 6 AIP = 1, bit 5 LA = 0).
- R5: After driving begins, the bus is judged after exactly ARB_CYC cycles. A losing device therefore drives BSY for exactly ARB_CYC cycles.
- R6: The highest numbered data bit has priority. The block loses when any bus_data_in bit above its own ID bit is 1 at the end of the delay.
- R7: If bus_sel_in is 1 during the arbitration delay, the block loses on the next clock edge.
- R8: On a loss, BSY and the ID bit are released in the same cycle LA sets, and status reads 8'h20. The block does not retry while arb_en stays 1.
- R9: When arb_en is 0, the block returns to idle on the next edge: nothing driven, and status reads 0 (AIP and LA cleared).
- R10: After a win, drv_bsy, drv_data = own_id and AIP are held until arb_en is cleared or host_sel is raised. host_sel releases them, and there is no new attempt until arb_en is cycled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_en | input | 1 | Arbitrate control bit from the register file |
| own_id | input | 8 | Outgoing data value holding the one-hot device ID |
| host_sel | input | 1 | Software request to assert SEL and start selection |
| bus_bsy_in | input | 1 | Sampled BSY line, 1 = asserted |
| bus_sel_in | input | 1 | Sampled SEL line, 1 = asserted |
| bus_data_in | input | 8 | Sampled data lines, 1 = asserted |
| drv_bsy | output | 1 | Assert BSY on the bus |
| drv_data | output | 8 | Data lines to assert (own ID bit while arbitrating) |
| status | output | 8 | Status byte: bit 6 AIP, bit 5 LA, others 0 |

## Verification
Priority is swept over every own ID bit paired with every competing bit, plus the no-competitor case. A competitor above wins, one below loses, and none means the device is alone. The bus-free wait is tried with a quiet window one cycle too short and with SEL held alone. These cases separate a true consecutive-cycle count from a plain level check. SEL arriving mid-delay, aborts from the arbitrate bit, invalid multi-bit or empty IDs, and the selection hand-off each confirm that the block releases the bus and that the status byte follows.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;

    localparam int BUS_W   = 8;
    localparam int AIP_POS = 6;
    localparam int LA_POS  = 5;

    typedef logic [BUS_W-1:0] bus_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FREE,
        ST_ARB,
        ST_WON,
        ST_DONE
    } arb_st_e;

    // true when some bit above the single set bit of id is asserted in seen
    function automatic logic outranked(input bus_t id, input bus_t seen);
        bus_t sh;
        sh = id << 1;
        return |(seen & ~(sh - bus_t'(1)));
    endfunction

    function automatic logic single_bit(input bus_t v);
        return $countones(v) == 1;
    endfunction

endpackage

// File: rtl/bus_free_det.sv
module bus_free_det #(
    parameter int FREE_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bsy,
    input  logic sel,
    output logic free
);
    localparam int CW = $clog2(FREE_CYC + 1);

    logic [CW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            quiet_cnt <= '0;
        else if (bsy || sel)
            quiet_cnt <= '0;
        else if (quiet_cnt != CW'(FREE_CYC))
            quiet_cnt <= quiet_cnt + CW'(1);
    end

    assign free = (quiet_cnt == CW'(FREE_CYC));

    // a busy cycle must restart the quiet window
    assert_busy_restarts_R3: assert property (@(posedge clk) disable iff (rst)
        (bsy || sel) |=> !free);

endmodule

// File: rtl/arb_delay_timer.sv
module arb_delay_timer #(
    parameter int ARB_CYC = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(ARB_CYC + 1);

    logic [CW-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst || !run)
            elapsed <= '0;
        else if (!expired)
            elapsed <= elapsed + CW'(1);
    end

    assign expired = (elapsed == CW'(ARB_CYC - 1));

    assert_timer_bound_R5: assert property (@(posedge clk) disable iff (rst)
        elapsed <= CW'(ARB_CYC - 1));

endmodule

// File: rtl/arb_outcome.sv
module arb_outcome
    import scsi_arb_pkg::*;
(
    input  bus_t own_id,
    input  bus_t bus_data,
    input  logic bus_sel,
    output logic sel_seen,
    output logic beaten
);
    assign sel_seen = bus_sel;
    assign beaten   = bus_sel || outranked(own_id, bus_data);
endmodule

// File: rtl/scsi_arb_ctrl.sv
module scsi_arb_ctrl
    import scsi_arb_pkg::*;
#(
    parameter int FREE_CYC = 3,
    parameter int ARB_CYC  = 300
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arb_en,
    input  logic [7:0] own_id,
    input  logic       host_sel,
    input  logic       bus_bsy_in,
    input  logic       bus_sel_in,
    input  logic [7:0] bus_data_in,
    output logic       drv_bsy,
    output logic [7:0] drv_data,
    output logic [7:0] status
);
    arb_st_e st;
    logic    la;
    logic    bus_free;
    logic    delay_done;
    logic    sel_seen;
    logic    beaten;
    logic    aip;

    bus_free_det #(.FREE_CYC(FREE_CYC)) u_free (
        .clk  (clk),
        .rst  (rst),
        .bsy  (bus_bsy_in),
        .sel  (bus_sel_in),
        .free (bus_free)
    );

    arb_delay_timer #(.ARB_CYC(ARB_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (st == ST_ARB),
        .expired (delay_done)
    );

    arb_outcome u_cmp (
        .own_id   (own_id),
        .bus_data (bus_data_in),
        .bus_sel  (bus_sel_in),
        .sel_seen (sel_seen),
        .beaten   (beaten)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            la <= 1'b0;
        end else if (!arb_en) begin
            st <= ST_IDLE;
            la <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE:
                    if (single_bit(own_id)) st <= ST_WAIT_FREE;
                ST_WAIT_FREE:
                    if (bus_free) st <= ST_ARB;
                ST_ARB:
                    if (sel_seen || (delay_done && beaten)) begin
                        st <= ST_DONE;
                        la <= 1'b1;
                    end else if (delay_done) begin
                        st <= ST_WON;
                    end
                ST_WON:
                    if (host_sel) st <= ST_DONE;
                ST_DONE:
                    st <= ST_DONE;
                default:
                    st <= ST_IDLE;
            endcase
        end
    end

    assign aip      = (st == ST_ARB) || (st == ST_WON);
    assign drv_bsy  = aip;
    assign drv_data = aip ? own_id : '0;

    always_comb begin
        status          = '0;
        status[AIP_POS] = aip;
        status[LA_POS]  = la;
    end

    assert_abort_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !arb_en |=> (status == 8'h00 && !drv_bsy));

    assert_sel_loses_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARB && arb_en && bus_sel_in) |=> (la && !drv_bsy));

    assert_drive_after_free_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_bsy) |-> $past(bus_free));

    assert_loss_releases_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(la) |-> (!drv_bsy && drv_data == 8'h00));

    assert_aip_la_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(status[AIP_POS] && status[LA_POS]));

endmodule

// File: tb/tb_scsi_arb_ctrl.sv
module tb_scsi_arb_ctrl;
    localparam int FREE = 3;
    localparam int DLY  = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic       arb_en;
    logic [7:0] own_id;
    logic       host_sel;
    logic       bsy_in;
    logic       sel_in;
    logic [7:0] data_in;
    logic       drv_bsy;
    logic [7:0] drv_data;
    logic [7:0] status;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    scsi_arb_ctrl #(.FREE_CYC(FREE), .ARB_CYC(DLY)) dut (
        .clk         (clk),
        .rst         (rst),
        .arb_en      (arb_en),
        .own_id      (own_id),
        .host_sel    (host_sel),
        .bus_bsy_in  (bsy_in),
        .bus_sel_in  (sel_in),
        .bus_data_in (data_in),
        .drv_bsy     (drv_bsy),
        .drv_data    (drv_data),
        .status      (status)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus busy, raise arb_en, then free the bus; returns cycles until drive
    task automatic start_arb(input logic [7:0] id, output int n);
        arb_en = 1'b0; bsy_in = 1'b1; sel_in = 1'b0; data_in = '0; host_sel = 1'b0;
        step(); step();
        own_id = id; arb_en = 1'b1;
        repeat (3) step();
        chk(drv_bsy == 1'b0, "R3 no drive while busy", drv_bsy, 0);
        bsy_in = 1'b0;
        n = 0;
        do begin step(); n++; end while (!drv_bsy && n < 20);
    endtask

    task automatic run_case(input int k, input int j);
        logic [7:0] id;
        logic [7:0] comp;
        int n;
        int m;
        bit lose;
        id   = 8'(1 << k);
        comp = (j < 0) ? 8'h00 : 8'(1 << j);
        lose = (j > k);
        start_arb(id, n);
        chk(n == FREE + 1, "R3 free-window latency", n, FREE + 1);
        data_in = id | comp;
        chk(status == 8'h40, "R4 aip status", status, 8'h40);
        chk(drv_data == id, "R2 id driven", drv_data, id);
        m = 1;
        for (int s = 0; s < DLY + 3; s++) begin
            step();
            if (!drv_bsy) break;
            m++;
        end
        if (lose) begin
            chk(m == DLY, "R5 delay length", m, DLY);
            chk(status == 8'h20, "R6 loss status", status, 8'h20);
            chk(drv_data == 8'h00, "R8 id released", drv_data, 0);
        end else begin
            chk(drv_bsy && status == 8'h40, "R6 win status", status, 8'h40);
            chk(drv_data == id, "R10 id held", drv_data, id);
        end
        arb_en = 1'b0;
        step();
        chk(status == 8'h00 && !drv_bsy, "R9 abort clears", status, 0);
    endtask

    initial begin
        int n;
        rst = 1'b1; arb_en = 1'b0; own_id = '0; host_sel = 1'b0;
        bsy_in = 1'b0; sel_in = 1'b0; data_in = '0;
        step(); step();
        rst = 1'b0;
        step();
        chk(drv_bsy == 0 && drv_data == 0 && status == 0, "R1 reset state", status, 0);

        // R6 priority sweep
        for (int k = 0; k < 8; k++)
            for (int j = -1; j < 8; j++)
                if (j != k) run_case(k, j);

        // R2 invalid IDs
        own_id = 8'h00; arb_en = 1'b1; bsy_in = 1'b0;
        repeat (10) step();
        chk(!drv_bsy && status == 0, "R2 empty id ignored", status, 0);
        own_id = 8'h11;
        repeat (10) step();
        chk(!drv_bsy && status == 0, "R2 multi-bit id ignored", drv_data, 0);
        arb_en = 1'b0; step();

        // R3 short quiet window and SEL-only busy
        own_id = 8'h04; bsy_in = 1'b1; arb_en = 1'b1;
        step(); step();
        bsy_in = 1'b0;
        repeat (FREE - 1) step();
        bsy_in = 1'b1;
        repeat (4) step();
        chk(!drv_bsy, "R3 short window rejected", drv_bsy, 0);
        bsy_in = 1'b0; sel_in = 1'b1;
        repeat (8) step();
        chk(!drv_bsy, "R3 SEL alone is busy", drv_bsy, 0);
        sel_in = 1'b0;
        n = 0;
        do begin step(); n++; end while (!drv_bsy && n < 20);
        chk(n == FREE + 1, "R3 latency after SEL", n, FREE + 1);
        step();
        arb_en = 1'b0;
        step();
        chk(!drv_bsy && status == 0, "R9 abort mid-delay", status, 0);

        // R7 SEL during arbitration
        start_arb(8'h80, n);
        data_in = 8'h80;
        step();
        sel_in = 1'b1;
        step();
        chk(!drv_bsy && status == 8'h20, "R7 SEL forces loss", status, 8'h20);
        sel_in = 1'b0;
        repeat (FREE + 4) step();
        chk(!drv_bsy && status == 8'h20, "R8 no retry after loss", status, 8'h20);
        arb_en = 1'b0; step();

        // R10 win then hand-off
        start_arb(8'h80, n);
        data_in = 8'h81;
        repeat (DLY + 2) step();
        chk(drv_bsy && status == 8'h40 && drv_data == 8'h80, "R10 win held", status, 8'h40);
        host_sel = 1'b1;
        step();
        chk(!drv_bsy && status == 0, "R10 hand-off releases", status, 0);
        host_sel = 1'b0;
        repeat (FREE + 3) step();
        chk(!drv_bsy, "R10 no restart after hand-off", drv_bsy, 0);
        arb_en = 1'b0; step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule